// File: doc/BRIEF.md
# Sensor-Indexed Operating Point Sequencer

This block chooses the supply voltage code, the two body-bias codes and the clock frequency for a core from a table of pre-characterized operating points. The row is selected by three live sensor readings: a quantized temperature code, a quantized average supply-current code reported by the external regulator, and a one-bit supply-droop flag. Each row holds the best regulator code, NMOS forward-bias code, PMOS bias code and frequency command for that combination of readings. The table and two timing fields are loaded through a simple addressed write port, which stands in for a serial scan load.

Operating point changes are applied in a safe order. When the new frequency is higher, the voltage and bias codes move first, and the frequency follows once a programmable settle timer runs out. When the new frequency is equal or lower, the frequency moves first and voltage and bias follow after the timer. The temperature and current codes pass through dwell filters, so a reading that flickers near a trip point does not make the outputs chatter. A rising droop flag skips both the filters and the timer and lowers the frequency in the next cycle.

The sequencer has three states: IDLE, UP_SETTLE and DN_SETTLE. The transitions are named as follows. IDLE goes to UP_SETTLE on "raise", which happens when the filtered index differs from the applied one and the target frequency is higher. IDLE goes to DN_SETTLE on "lower" in the other case. UP_SETTLE goes to IDLE on "up_done" and DN_SETTLE goes to IDLE on "dn_done", each when its timer is zero. Any state goes to DN_SETTLE on "droop" when the droop flag rises.

Top module: `opt_point_ctrl`

## Requirements
- R1: While `rst_n` is low, all voltage, bias and frequency outputs are zero, and `busy_o` and `clk_upd_o` are low.
- R2: The row index is {droop, temperature[2:0], current[1:0]}. A row is written with `cfg_addr_i[6]`=0 and the row number in `cfg_addr_i[5:0]`. Row data is {vrm[22:15], nbias[14:11], pbias[10:6], freq[5:0]}. Address 0x40 writes the settle count and 0x41 writes the dwell count, both taken from the low 12 bits of the data.
- R3: When the target frequency code is greater than the applied one, the voltage and bias outputs change first. The frequency command follows settle+1 cycles later.
- R4: When the target frequency code is not greater than the applied one, the frequency command is issued first. The voltage and bias outputs follow settle+1 cycles later.
- R5: `busy_o` is high while a sequenced change is in progress. A change of index during that time has no effect until the sequencer returns to IDLE, and it starts on the next cycle after that return. No output moves without a pending table change.
- R6: A new temperature or current code takes effect only after it has been held steady for dwell+2 cycles. A reading that lasts for a shorter time leaves all outputs unchanged.
- R7: A rising edge on `droop_i` aborts any sequence in progress. It issues the frequency of the droop row on the next clock edge, and that row's voltage and bias follow settle+1 cycles later.
- R8: `pbias_o` is a two's-complement code in 32 mV steps, where negative values mean reverse bias. `nbias_o` is unsigned forward bias. Both pass from the table unchanged.
- R9: Every frequency command is a one-cycle `clk_upd_o` pulse. `clk_pll_o` carries freq[5:4] as the PLL select and `clk_div_o` carries freq[3:0] as the divider value. A larger code means a faster clock.
- R10: A table write made during a sequence does not alter the target values of the sequence in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| temp_code_i | input | 3 | Quantized thermal sensor code |
| cur_code_i | input | 2 | Average supply-current code from regulator |
| droop_i | input | 1 | Supply droop detected |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 7 | Row number or configuration field address |
| cfg_wdata_i | input | 23 | Row contents or field value |
| vrm_code_o | output | 8 | Regulator voltage code |
| nbias_o | output | 4 | NMOS forward body-bias code |
| pbias_o | output | 5 | PMOS body-bias code, signed |
| clk_pll_o | output | 2 | PLL select for the clocking unit |
| clk_div_o | output | 4 | Divider value for the clocking unit |
| clk_upd_o | output | 1 | Frequency command strobe |
| busy_o | output | 1 | Sequenced transition in progress |

## Verification
The hardest situation to reach is an index change that arrives while UP_SETTLE is still counting, at the same moment as a rewrite of the row being applied. That change must wait, and it must then launch as a downward step exactly one cycle after the held frequency is issued. The stimulus gets there by waiting at the ports for `busy_o` to rise, then moving the current code and rewriting the active row while the timer runs. The scoreboard then expects the original frequency followed by the new command one cycle later. A second case asserts droop a second time while an upward step is still settling, which checks that the pending frequency raise is dropped.

// File: rtl/opc_pkg.sv
package opc_pkg;
    localparam int TEMP_W = 3;
    localparam int CUR_W  = 2;
    localparam int IDX_W  = 1 + TEMP_W + CUR_W;
    localparam int DEPTH  = 1 << IDX_W;
    localparam int VRM_W  = 8;
    localparam int NB_W   = 4;
    localparam int PB_W   = 5;
    localparam int PLL_W  = 2;
    localparam int DIV_W  = 4;
    localparam int FQ_W   = PLL_W + DIV_W;
    localparam int TMR_W  = 12;

    typedef struct packed {
        logic [VRM_W-1:0] vrm;
        logic [NB_W-1:0]  nb;
        logic [PB_W-1:0]  pb;
        logic [FQ_W-1:0]  fq;
    } op_point_t;

    localparam int ENT_W = $bits(op_point_t);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_UP_SETTLE,
        ST_DN_SETTLE
    } seq_st_e;
endpackage

// File: rtl/opc_hyst.sv
module opc_hyst #(
    parameter int W   = 3,
    parameter int T_W = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [W-1:0]   raw_i,
    input  logic [T_W-1:0] dwell_i,
    output logic [W-1:0]   code_o
);
    logic [W-1:0]   acc_q;
    logic [W-1:0]   cand_q;
    logic [T_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q  <= '0;
            cand_q <= '0;
            cnt_q  <= '0;
        end else if (raw_i == acc_q) begin
            cand_q <= acc_q;
            cnt_q  <= '0;
        end else if (raw_i != cand_q) begin
            cand_q <= raw_i;
            cnt_q  <= '0;
        end else if (cnt_q == dwell_i) begin
            acc_q  <= raw_i;
            cnt_q  <= '0;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign code_o = acc_q;
endmodule

// File: rtl/opc_table.sv
module opc_table
    import opc_pkg::*;
#(
    parameter int A_W = IDX_W,
    parameter int N   = DEPTH
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we_i,
    input  logic [A_W-1:0] waddr_i,
    input  op_point_t      wdata_i,
    input  logic [A_W-1:0] raddr_i,
    output op_point_t      rdata_o
);
    op_point_t rows [N];

    for (genvar g = 0; g < N; g++) begin : g_row
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rows[g] <= '0;
            end else if (we_i && (waddr_i == A_W'(g))) begin
                rows[g] <= wdata_i;
            end
        end
    end

    assign rdata_o = rows[raddr_i];
endmodule

// File: rtl/opc_seq.sv
module opc_seq
    import opc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx_i,
    input  op_point_t        row_i,
    input  logic             droop_i,
    input  logic [TMR_W-1:0] settle_i,
    output logic [VRM_W-1:0] vrm_o,
    output logic [NB_W-1:0]  nb_o,
    output logic [PB_W-1:0]  pb_o,
    output logic [FQ_W-1:0]  fq_o,
    output logic             upd_o,
    output logic             busy_o
);
    seq_st_e          st_q, st_d;
    op_point_t        tgt_q;
    logic [IDX_W-1:0] app_q;
    logic [TMR_W-1:0] tmr_q;
    logic             droop_q;
    logic             droop_rise;
    logic             idx_new;
    logic             go_up;

    assign droop_rise = droop_i & ~droop_q;
    assign idx_new    = (idx_i != app_q);
    assign go_up      = (row_i.fq > fq_o);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        if (droop_rise) begin
            st_d = ST_DN_SETTLE;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (idx_new) st_d = go_up ? ST_UP_SETTLE : ST_DN_SETTLE;
                end
                ST_UP_SETTLE: begin
                    if (tmr_q == '0) st_d = ST_IDLE;
                end
                ST_DN_SETTLE: begin
                    if (tmr_q == '0) st_d = ST_IDLE;
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_q   <= '0;
            app_q   <= '0;
            tmr_q   <= '0;
            droop_q <= 1'b0;
            vrm_o   <= '0;
            nb_o    <= '0;
            pb_o    <= '0;
            fq_o    <= '0;
            upd_o   <= 1'b0;
        end else begin
            droop_q <= droop_i;
            upd_o   <= 1'b0;
            if (droop_rise) begin
                tgt_q <= row_i;
                app_q <= idx_i;
                tmr_q <= settle_i;
                fq_o  <= row_i.fq;
                upd_o <= 1'b1;
            end else begin
                unique case (st_q)
                    ST_IDLE: begin
                        if (idx_new) begin
                            tgt_q <= row_i;
                            app_q <= idx_i;
                            tmr_q <= settle_i;
                            if (go_up) begin
                                vrm_o <= row_i.vrm;
                                nb_o  <= row_i.nb;
                                pb_o  <= row_i.pb;
                            end else begin
                                fq_o  <= row_i.fq;
                                upd_o <= 1'b1;
                            end
                        end
                    end
                    ST_UP_SETTLE: begin
                        if (tmr_q == '0) begin
                            fq_o  <= tgt_q.fq;
                            upd_o <= 1'b1;
                        end else begin
                            tmr_q <= tmr_q - 1'b1;
                        end
                    end
                    ST_DN_SETTLE: begin
                        if (tmr_q == '0) begin
                            vrm_o <= tgt_q.vrm;
                            nb_o  <= tgt_q.nb;
                            pb_o  <= tgt_q.pb;
                        end else begin
                            tmr_q <= tmr_q - 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign busy_o = (st_q != ST_IDLE);
endmodule

// File: rtl/opt_point_ctrl.sv
module opt_point_ctrl
    import opc_pkg::*;
#(
    parameter int RST_SETTLE = 8,
    parameter int RST_DWELL  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TEMP_W-1:0] temp_code_i,
    input  logic [CUR_W-1:0]  cur_code_i,
    input  logic              droop_i,
    input  logic              cfg_we_i,
    input  logic [IDX_W:0]    cfg_addr_i,
    input  logic [ENT_W-1:0]  cfg_wdata_i,
    output logic [VRM_W-1:0]  vrm_code_o,
    output logic [NB_W-1:0]   nbias_o,
    output logic [PB_W-1:0]   pbias_o,
    output logic [PLL_W-1:0]  clk_pll_o,
    output logic [DIV_W-1:0]  clk_div_o,
    output logic              clk_upd_o,
    output logic              busy_o
);
    localparam logic [IDX_W:0] A_SETTLE = (IDX_W+1)'(1 << IDX_W);
    localparam logic [IDX_W:0] A_DWELL  = (IDX_W+1)'((1 << IDX_W) + 1);

    logic [TMR_W-1:0]  settle_q;
    logic [TMR_W-1:0]  dwell_q;
    logic [TEMP_W-1:0] temp_f;
    logic [CUR_W-1:0]  cur_f;
    logic [IDX_W-1:0]  idx;
    logic              row_we;
    op_point_t         row;
    logic [FQ_W-1:0]   fq;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            settle_q <= TMR_W'(RST_SETTLE);
            dwell_q  <= TMR_W'(RST_DWELL);
        end else if (cfg_we_i) begin
            if (cfg_addr_i == A_SETTLE) settle_q <= cfg_wdata_i[TMR_W-1:0];
            if (cfg_addr_i == A_DWELL)  dwell_q  <= cfg_wdata_i[TMR_W-1:0];
        end
    end

    assign row_we = cfg_we_i & ~cfg_addr_i[IDX_W];

    opc_hyst #(.W(TEMP_W), .T_W(TMR_W)) u_temp_filt (
        .clk(clk), .rst_n(rst_n), .raw_i(temp_code_i), .dwell_i(dwell_q), .code_o(temp_f)
    );

    opc_hyst #(.W(CUR_W), .T_W(TMR_W)) u_cur_filt (
        .clk(clk), .rst_n(rst_n), .raw_i(cur_code_i), .dwell_i(dwell_q), .code_o(cur_f)
    );

    assign idx = {droop_i, temp_f, cur_f};

    opc_table #(.A_W(IDX_W), .N(DEPTH)) u_table (
        .clk(clk), .rst_n(rst_n), .we_i(row_we), .waddr_i(cfg_addr_i[IDX_W-1:0]),
        .wdata_i(op_point_t'(cfg_wdata_i)), .raddr_i(idx), .rdata_o(row)
    );

    opc_seq u_seq (
        .clk(clk), .rst_n(rst_n), .idx_i(idx), .row_i(row), .droop_i(droop_i),
        .settle_i(settle_q), .vrm_o(vrm_code_o), .nb_o(nbias_o), .pb_o(pbias_o),
        .fq_o(fq), .upd_o(clk_upd_o), .busy_o(busy_o)
    );

    assign clk_pll_o = fq[FQ_W-1:DIV_W];
    assign clk_div_o = fq[DIV_W-1:0];
endmodule

// File: rtl/opc_checker.sv
module opc_checker
    import opc_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             droop_i,
    input logic             busy_o,
    input logic             clk_upd_o,
    input logic [PLL_W-1:0] clk_pll_o,
    input logic [DIV_W-1:0] clk_div_o,
    input logic [VRM_W-1:0] vrm_code_o,
    input logic [NB_W-1:0]  nbias_o,
    input logic [PB_W-1:0]  pbias_o
);
    logic [VRM_W+NB_W+PB_W-1:0] vb;
    logic [FQ_W-1:0]            fq;
    assign vb = {vrm_code_o, nbias_o, pbias_o};
    assign fq = {clk_pll_o, clk_div_o};

    assert_freq_strobed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fq != $past(fq)) |-> clk_upd_o);

    assert_busy_rise_acts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (clk_upd_o || (vb != $past(vb))));

    assert_vb_at_edges_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (vb != $past(vb)) |-> ($rose(busy_o) || $fell(busy_o)));

    assert_droop_immediate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (droop_i && !$past(droop_i)) |=> clk_upd_o);
endmodule

bind opt_point_ctrl opc_checker u_opc_checker (
    .clk(clk), .rst_n(rst_n), .droop_i(droop_i), .busy_o(busy_o),
    .clk_upd_o(clk_upd_o), .clk_pll_o(clk_pll_o), .clk_div_o(clk_div_o),
    .vrm_code_o(vrm_code_o), .nbias_o(nbias_o), .pbias_o(pbias_o)
);

// File: tb/test_opt_point_ctrl.sv
module test_opt_point_ctrl;
    import opc_pkg::*;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic              rst_n;
    logic [TEMP_W-1:0] temp_code;
    logic [CUR_W-1:0]  cur_code;
    logic              droop;
    logic              cfg_we;
    logic [IDX_W:0]    cfg_addr;
    logic [ENT_W-1:0]  cfg_wdata;
    logic [VRM_W-1:0]  vrm_code;
    logic [NB_W-1:0]   nbias;
    logic [PB_W-1:0]   pbias;
    logic [PLL_W-1:0]  clk_pll;
    logic [DIV_W-1:0]  clk_div;
    logic              clk_upd;
    logic              busy;

    opt_point_ctrl i_opt_point_ctrl (
        .clk(clk), .rst_n(rst_n), .temp_code_i(temp_code), .cur_code_i(cur_code),
        .droop_i(droop), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
        .vrm_code_o(vrm_code), .nbias_o(nbias), .pbias_o(pbias), .clk_pll_o(clk_pll),
        .clk_div_o(clk_div), .clk_upd_o(clk_upd), .busy_o(busy)
    );

    typedef struct {
        int          kind;
        logic [31:0] val;
        int          gap;
        string       req;
    } exp_t;

    exp_t        sb[$];
    int          n_cmp = 0;
    int          n_bad = 0;
    int          cyc = 0;
    int          last_ref = 0;
    bit          mon_on = 1'b0;
    bit          done = 1'b0;
    logic [16:0] prev_vb = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [ENT_W-1:0] mk(input logic [7:0] v, input logic [3:0] n,
                                            input logic [4:0] p, input logic [5:0] f);
        return {v, n, p, f};
    endfunction

    task automatic push_vb(input logic [7:0] v, input logic [3:0] n, input logic [4:0] p,
                           input int gap, input string req);
        exp_t e;
        e.kind = 0; e.val = 32'({v, n, p}); e.gap = gap; e.req = req;
        sb.push_back(e);
    endtask

    task automatic push_fq(input logic [5:0] f, input int gap, input string req);
        exp_t e;
        e.kind = 1; e.val = 32'(f); e.gap = gap; e.req = req;
        sb.push_back(e);
    endtask

    task automatic pop_cmp(input int kind, input logic [31:0] val);
        exp_t e;
        if (sb.size() == 0) begin
            chk(1'b0, "R5", "unexpected output event", val, 32'hffff_ffff);
        end else begin
            e = sb.pop_front();
            chk(e.kind == kind && e.val == val, e.req, "event kind/value",
                32'(kind * 'h100000) | val, 32'(e.kind * 'h100000) | e.val);
            if (e.gap >= 0) chk(cyc - last_ref == e.gap, e.req, "event spacing",
                                32'(cyc - last_ref), 32'(e.gap));
        end
        last_ref = cyc;
    endtask

    always @(negedge clk) begin
        if (mon_on) begin
            logic [16:0] vb;
            cyc++;
            vb = {vrm_code, nbias, pbias};
            if (vb != prev_vb) pop_cmp(0, 32'(vb));
            if (clk_upd) pop_cmp(1, 32'({clk_pll, clk_div}));
            prev_vb = vb;
        end
    end

    task automatic cfg_wr(input logic [IDX_W:0] a, input logic [ENT_W-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic at_drive();
        @(negedge clk);
        #1;
        last_ref = cyc;
    endtask

    task automatic wait_busy();
        do @(negedge clk); while (!busy);
        #1;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R5 watchdog expired actual=%0d expected=%0d", cyc, 0);
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; temp_code = '0; cur_code = '0; droop = 1'b0;
        cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(vrm_code == 0 && nbias == 0 && pbias == 0, "R1", "vb in reset",
            32'({vrm_code, nbias, pbias}), 0);
        chk({clk_pll, clk_div} == 0, "R1", "freq in reset", 32'({clk_pll, clk_div}), 0);
        chk(!busy && !clk_upd, "R1", "busy/upd in reset", 32'({busy, clk_upd}), 0);
        rst_n = 1'b1;
        mon_on = 1'b1;

        // R2 programming: settle 5, dwell 2, rows by {droop,temp,cur}
        cfg_wr(7'h40, 23'd5);
        cfg_wr(7'h41, 23'd2);
        cfg_wr(7'd4,  mk(8'h60, 4'd3, 5'h1e, 6'h25));
        cfg_wr(7'd6,  mk(8'h40, 4'd1, 5'h05, 6'h12));
        cfg_wr(7'd10, mk(8'h70, 4'd5, 5'h07, 6'h30));
        cfg_wr(7'd11, mk(8'h50, 4'd2, 5'h1c, 6'h20));
        cfg_wr(7'd43, mk(8'h30, 4'd0, 5'h18, 6'h08));
        repeat (4) @(negedge clk);

        // R3 upward step with R6 dwell latency and R8 negative pbias
        push_vb(8'h60, 4'd3, 5'h1e, 5, "R6");
        push_fq(6'h25, 6, "R3");
        at_drive(); temp_code = 3'd1;
        repeat (15) @(negedge clk);

        // R4 downward step
        push_fq(6'h12, 5, "R4");
        push_vb(8'h40, 4'd1, 5'h05, 6, "R4");
        at_drive(); cur_code = 2'd2;
        repeat (15) @(negedge clk);

        // R6 short glitch on temperature is ignored
        at_drive(); temp_code = 3'd3;
        repeat (2) @(negedge clk);
        #1 temp_code = 3'd1;
        repeat (20) @(negedge clk);
        chk({vrm_code, nbias, pbias} == {8'h40, 4'd1, 5'h05}, "R6", "vb after glitch",
            32'({vrm_code, nbias, pbias}), 32'({8'h40, 4'd1, 5'h05}));
        chk({clk_pll, clk_div} == 6'h12 && !busy, "R6", "freq after glitch",
            32'({busy, clk_pll, clk_div}), 32'h12);

        // R5 change held while busy, R10 row rewrite during sequence
        push_vb(8'h70, 4'd5, 5'h07, 5, "R3");
        push_fq(6'h30, 6, "R10");
        push_fq(6'h20, 1, "R5");
        push_vb(8'h50, 4'd2, 5'h1c, 6, "R4");
        at_drive(); temp_code = 3'd2;
        wait_busy();
        cur_code = 2'd3;
        chk(busy, "R5", "busy during settle", 32'(busy), 1);
        cfg_wr(7'd10, mk(8'h11, 4'd7, 5'h0f, 6'h3f));
        repeat (20) @(negedge clk);

        // R7 droop from idle
        push_fq(6'h08, 1, "R7");
        push_vb(8'h30, 4'd0, 5'h18, 6, "R7");
        at_drive(); droop = 1'b1;
        repeat (15) @(negedge clk);

        // R7 droop aborts an upward step in progress; R9 strobe values
        push_vb(8'h50, 4'd2, 5'h1c, 1, "R3");
        push_fq(6'h08, 1, "R9");
        push_vb(8'h30, 4'd0, 5'h18, 6, "R7");
        at_drive(); droop = 1'b0;
        wait_busy();
        last_ref = cyc;
        droop = 1'b1;
        repeat (25) @(negedge clk);

        chk(sb.size() == 0, "R5", "events still pending", 32'(sb.size()), 0);
        chk(!busy, "R5", "busy at end", 32'(busy), 0);
        chk({clk_pll, clk_div} == 6'h08, "R9", "final freq", 32'({clk_pll, clk_div}), 32'h08);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule